// File: doc/BRIEF.md
# USART Control Word Sequencer

This block sits between a host bus and the serial engines of a programmable serial controller. It decodes active-low chip select, read and write strobes and a control/data select line. It turns each strobe into a single action: it loads a transmit byte, writes a setup word or a command, or returns a receive byte or the status word.

Control writes have no fixed meaning. A small state machine gives each one its meaning, and the machine restarts after any reset. The states are SEQ_MODE (waiting for the mode word), SEQ_SYNC_A (waiting for the first sync character), SEQ_SYNC_B (waiting for the second sync character) and SEQ_CMD (every control write is a command). The transitions are as follows:
- SEQ_MODE goes to SEQ_SYNC_A when a mode word selects synchronous operation. It goes to SEQ_CMD when the mode word selects an asynchronous rate.
- SEQ_SYNC_A goes to SEQ_CMD when the mode asks for a single sync character. Otherwise it goes to SEQ_SYNC_B.
- SEQ_SYNC_B always goes to SEQ_CMD.
- SEQ_CMD goes back to SEQ_MODE on a command with the internal-reset bit set.
- An external reset forces SEQ_MODE from any state.

The stored mode fields, the sync characters and the command-driven levels go out to the shifter, the baud generator and the modem pins. Serial shifting is not part of this block.

Top module: `usart_ctrl_seq`

## Requirements
- R1: While cs_n is high, strobes have no effect on any register or pulse output. dout reads 0 whenever cs_n or rd_n is high.
- R2: Each low pulse of the write strobe, with cs_n low, is acted on exactly once, on its first clock. A data write (cd=0) loads tx_data, and tx_load is high for the one cycle after that clock.
- R3: While cs_n and rd_n are low, dout shows rx_data when cd=0 and status_in when cd=1. A data read raises rx_take for one cycle after its first clock. A status read does not raise rx_take.
- R4: After any reset, the first control write (cd=1) is stored as the mode word. baud_sel is bit 1:0 (00 means synchronous; 01, 10 and 11 mean ×1, ×16 and ×64). char_len is bits 3:2 (00 means 5 bits up to 11 meaning 8 bits). par_en is bit 4, par_even is bit 5 and frame_hi is bits 7:6.
- R5: When baud_sel is 00, the control writes after the mode word are sync characters. With mode bit 7 set, one write loads sync_a. With mode bit 7 clear, two writes load sync_a and then sync_b. An asynchronous mode takes no sync characters.
- R6: In the command phase, a control write replaces all command levels at once. Bit 0 is transmit enable, bit 2 is receive enable and bit 3 is break. Bit 1 drives DTR and bit 5 drives RTS. dtr_n and rts_n are the inverses of their bits.
- R7: A command with bit 4 set (and bit 6 clear) makes err_clr high for exactly one cycle.
- R8: A command with bit 6 set clears tx_en, rx_en and brk and sets dtr_n and rts_n high. All other bits of that command are ignored. The next control write is then taken as a mode word. The mode fields keep their values until that write.
- R9: While rst is high, the block returns to its reset state. dtr_n and rts_n are 1. tx_en, rx_en, brk and the pulses are 0. The mode fields, the sync characters and tx_data are 0. The next control write is taken as a mode word.
- R10: In the sync and command phases, the mode fields never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous external reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cd | input | 1 | 1 selects control/status, 0 selects data |
| din | input | DW | Write data from the host |
| dout | output | DW | Read data to the host |
| rx_data | input | DW | Byte from the receive engine |
| status_in | input | DW | Status word assembled by the serial engines |
| tx_data | output | DW | Byte for the transmit engine |
| tx_load | output | 1 | One-cycle pulse: tx_data is new |
| rx_take | output | 1 | One-cycle pulse: the host read the receive byte |
| baud_sel | output | 2 | Rate factor field of the mode word |
| char_len | output | 2 | Character length field |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| frame_hi | output | 2 | Mode bits 7:6 |
| sync_a | output | DW | First sync character |
| sync_b | output | DW | Second sync character |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| brk | output | 1 | Force break on the line |
| err_clr | output | 1 | One-cycle pulse clearing the error flags |
| dtr_n | output | 1 | DTR pin, active low |
| rts_n | output | 1 | RTS pin, active low |

## Verification
The bench holds each strobe low for two clocks. A design that acts on a level instead of an edge would then load twice, or would step the sequencer past a sync slot. The bench walks both sync-character paths and the asynchronous path, so a wrong mode-bit decode would misfile a sync byte as a command. It also sends a command with the internal-reset bit and all other bits set; a design that let those bits through would leave the transmitter enabled. It asserts the external reset in the middle of a sync sequence, and a design that kept the old phase would store the next mode word as a sync character.

// File: rtl/usart_seq_pkg.sv
package usart_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_MODE   = 2'd0,
        SEQ_SYNC_A = 2'd1,
        SEQ_SYNC_B = 2'd2,
        SEQ_CMD    = 2'd3
    } seq_state_t;

    // command word bit positions
    localparam int CB_TXEN  = 0;
    localparam int CB_DTR   = 1;
    localparam int CB_RXEN  = 2;
    localparam int CB_BRK   = 3;
    localparam int CB_ERRC  = 4;
    localparam int CB_RTS   = 5;
    localparam int CB_IRST  = 6;
    localparam int CMD_USED = 7;

    // mode word bit positions
    localparam int MB_SYNC_ONE = 7;

endpackage

// File: rtl/usart_bus_decode.sv
module usart_bus_decode (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic cd,
    output logic ctl_wr,
    output logic dat_wr,
    output logic dat_rd,
    output logic rd_on
);

    logic wr_act, rd_act;
    logic wr_prev, rd_prev;

    assign wr_act = ~cs_n & ~wr_n;
    assign rd_act = ~cs_n & ~rd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev <= 1'b0;
            rd_prev <= 1'b0;
        end else begin
            wr_prev <= wr_act;
            rd_prev <= rd_act;
        end
    end

    assign ctl_wr = wr_act & ~wr_prev & cd;
    assign dat_wr = wr_act & ~wr_prev & ~cd;
    assign dat_rd = rd_act & ~rd_prev & ~cd;
    assign rd_on  = rd_act;

endmodule

// File: rtl/usart_seq_fsm.sv
module usart_seq_fsm
    import usart_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic       new_is_sync,
    input  logic       one_sync,
    input  logic       irst_bit,
    output seq_state_t state,
    output logic       mode_ld,
    output logic       sync_a_ld,
    output logic       sync_b_ld,
    output logic       cmd_ld,
    output logic       irst_ld
);

    seq_state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_MODE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (ctl_wr) begin
            unique case (state)
                SEQ_MODE:   state_nx = new_is_sync ? SEQ_SYNC_A : SEQ_CMD;
                SEQ_SYNC_A: state_nx = one_sync ? SEQ_CMD : SEQ_SYNC_B;
                SEQ_SYNC_B: state_nx = SEQ_CMD;
                SEQ_CMD:    state_nx = irst_bit ? SEQ_MODE : SEQ_CMD;
            endcase
        end
    end

    always_comb begin
        mode_ld   = 1'b0;
        sync_a_ld = 1'b0;
        sync_b_ld = 1'b0;
        cmd_ld    = 1'b0;
        irst_ld   = 1'b0;
        if (ctl_wr) begin
            unique case (state)
                SEQ_MODE:   mode_ld   = 1'b1;
                SEQ_SYNC_A: sync_a_ld = 1'b1;
                SEQ_SYNC_B: sync_b_ld = 1'b1;
                SEQ_CMD: begin
                    irst_ld = irst_bit;
                    cmd_ld  = ~irst_bit;
                end
            endcase
        end
    end

endmodule

// File: rtl/usart_cfg_regs.sv
module usart_cfg_regs
    import usart_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          mode_ld,
    input  logic          sync_a_ld,
    input  logic          sync_b_ld,
    output logic [1:0]    baud_sel,
    output logic [1:0]    char_len,
    output logic          par_en,
    output logic          par_even,
    output logic [1:0]    frame_hi,
    output logic          one_sync,
    output logic [DW-1:0] sync_a,
    output logic [DW-1:0] sync_b
);

    logic [DW-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            sync_a <= '0;
            sync_b <= '0;
        end else begin
            if (mode_ld)   mode_q <= din;
            if (sync_a_ld) sync_a <= din;
            if (sync_b_ld) sync_b <= din;
        end
    end

    assign baud_sel = mode_q[1:0];
    assign char_len = mode_q[3:2];
    assign par_en   = mode_q[4];
    assign par_even = mode_q[5];
    assign frame_hi = mode_q[7:6];
    assign one_sync = mode_q[MB_SYNC_ONE];

endmodule

// File: rtl/usart_cmd_regs.sv
module usart_cmd_regs
    import usart_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_ld,
    input  logic                irst_ld,
    input  logic [CMD_USED-1:0] cmd,
    output logic                tx_en,
    output logic                rx_en,
    output logic                brk,
    output logic                err_clr,
    output logic                dtr_n,
    output logic                rts_n
);

    logic dtr_q, rts_q;

    always_ff @(posedge clk) begin
        if (rst || irst_ld) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
            brk   <= 1'b0;
            dtr_q <= 1'b0;
            rts_q <= 1'b0;
        end else if (cmd_ld) begin
            tx_en <= cmd[CB_TXEN];
            rx_en <= cmd[CB_RXEN];
            brk   <= cmd[CB_BRK];
            dtr_q <= cmd[CB_DTR];
            rts_q <= cmd[CB_RTS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_clr <= 1'b0;
        else     err_clr <= cmd_ld & cmd[CB_ERRC];
    end

    assign dtr_n = ~dtr_q;
    assign rts_n = ~rts_q;

endmodule

// File: rtl/usart_ctrl_seq.sv
module usart_ctrl_seq
    import usart_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          cd,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic [DW-1:0] rx_data,
    input  logic [DW-1:0] status_in,
    output logic [DW-1:0] tx_data,
    output logic          tx_load,
    output logic          rx_take,
    output logic [1:0]    baud_sel,
    output logic [1:0]    char_len,
    output logic          par_en,
    output logic          par_even,
    output logic [1:0]    frame_hi,
    output logic [DW-1:0] sync_a,
    output logic [DW-1:0] sync_b,
    output logic          tx_en,
    output logic          rx_en,
    output logic          brk,
    output logic          err_clr,
    output logic          dtr_n,
    output logic          rts_n
);

    logic       ctl_wr, dat_wr, dat_rd, rd_on;
    logic       mode_ld, sync_a_ld, sync_b_ld, cmd_ld, irst_ld;
    logic       one_sync;
    seq_state_t seq_state;

    usart_bus_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .rd_n   (rd_n),
        .cd     (cd),
        .ctl_wr (ctl_wr),
        .dat_wr (dat_wr),
        .dat_rd (dat_rd),
        .rd_on  (rd_on)
    );

    usart_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ctl_wr      (ctl_wr),
        .new_is_sync (din[1:0] == 2'b00),
        .one_sync    (one_sync),
        .irst_bit    (din[CB_IRST]),
        .state       (seq_state),
        .mode_ld     (mode_ld),
        .sync_a_ld   (sync_a_ld),
        .sync_b_ld   (sync_b_ld),
        .cmd_ld      (cmd_ld),
        .irst_ld     (irst_ld)
    );

    usart_cfg_regs #(.DW(DW)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .mode_ld   (mode_ld),
        .sync_a_ld (sync_a_ld),
        .sync_b_ld (sync_b_ld),
        .baud_sel  (baud_sel),
        .char_len  (char_len),
        .par_en    (par_en),
        .par_even  (par_even),
        .frame_hi  (frame_hi),
        .one_sync  (one_sync),
        .sync_a    (sync_a),
        .sync_b    (sync_b)
    );

    usart_cmd_regs u_cmd (
        .clk     (clk),
        .rst     (rst),
        .cmd_ld  (cmd_ld),
        .irst_ld (irst_ld),
        .cmd     (din[CMD_USED-1:0]),
        .tx_en   (tx_en),
        .rx_en   (rx_en),
        .brk     (brk),
        .err_clr (err_clr),
        .dtr_n   (dtr_n),
        .rts_n   (rts_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_data <= '0;
            tx_load <= 1'b0;
            rx_take <= 1'b0;
        end else begin
            if (dat_wr) tx_data <= din;
            tx_load <= dat_wr;
            rx_take <= dat_rd;
        end
    end

    always_comb begin
        if (!rd_on)  dout = '0;
        else if (cd) dout = status_in;
        else         dout = rx_data;
    end

endmodule

// File: rtl/usart_ctrl_seq_chk.sv
module usart_ctrl_seq_chk
    import usart_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          wr_n,
    input logic          rd_n,
    input logic          cd,
    input logic [DW-1:0] dout,
    input logic          tx_load,
    input logic          rx_take,
    input logic [1:0]    baud_sel,
    input logic [1:0]    char_len,
    input logic          par_en,
    input logic          par_even,
    input logic [1:0]    frame_hi,
    input logic          tx_en,
    input logic          rx_en,
    input logic          brk,
    input logic          err_clr,
    input logic          dtr_n,
    input logic          rts_n,
    input logic [1:0]    seq_state
);

    logic [7:0] mode_view;
    logic [4:0] cmd_view;
    assign mode_view = {frame_hi, par_even, par_en, char_len, baud_sel};
    assign cmd_view  = {tx_en, rx_en, brk, dtr_n, rts_n};

    a_r1_no_cs_no_change: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(mode_view) && $stable(cmd_view) && !tx_load && !err_clr && !rx_take));

    a_r1_dout_idle: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (dout == '0));

    a_r2_tx_load_single: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);

    a_r2_tx_load_cause: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> $past(!cs_n && !wr_n && !cd));

    a_r3_rx_take_cause: assert property (@(posedge clk) disable iff (rst)
        rx_take |-> $past(!cs_n && !rd_n && !cd));

    a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> !err_clr);

    a_r8_irst_clears: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SEQ_CMD) ##1 (seq_state == SEQ_MODE)
        |-> (!tx_en && !rx_en && !brk && dtr_n && rts_n));

    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (dtr_n && rts_n && !tx_en && !rx_en && !brk && !tx_load
                 && !err_clr && seq_state == SEQ_MODE));

    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        (seq_state != SEQ_MODE) |=> $stable(mode_view));

endmodule

bind usart_ctrl_seq usart_ctrl_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .cd        (cd),
    .dout      (dout),
    .tx_load   (tx_load),
    .rx_take   (rx_take),
    .baud_sel  (baud_sel),
    .char_len  (char_len),
    .par_en    (par_en),
    .par_even  (par_even),
    .frame_hi  (frame_hi),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .brk       (brk),
    .err_clr   (err_clr),
    .dtr_n     (dtr_n),
    .rts_n     (rts_n),
    .seq_state (seq_state)
);

// File: tb/test_usart_ctrl_seq.sv
module test_usart_ctrl_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cd = 1'b0;
    logic [7:0] din = 8'h00, rx_data = 8'h3C, status_in = 8'h85;
    logic [7:0] dout, tx_data, sync_a, sync_b;
    logic       tx_load, rx_take, par_en, par_even, tx_en, rx_en, brk, err_clr, dtr_n, rts_n;
    logic [1:0] baud_sel, char_len, frame_hi;

    always #4 clk = ~clk;

    usart_ctrl_seq #(.DW(8)) i_usart_ctrl_seq (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .cd(cd),
        .din(din), .dout(dout), .rx_data(rx_data), .status_in(status_in),
        .tx_data(tx_data), .tx_load(tx_load), .rx_take(rx_take),
        .baud_sel(baud_sel), .char_len(char_len), .par_en(par_en), .par_even(par_even),
        .frame_hi(frame_hi), .sync_a(sync_a), .sync_b(sync_b),
        .tx_en(tx_en), .rx_en(rx_en), .brk(brk), .err_clr(err_clr),
        .dtr_n(dtr_n), .rts_n(rts_n)
    );

    int checks = 0;
    int errors = 0;
    bit go = 1'b0;

    // reference model: 0 wait mode, 1 first sync, 2 second sync, 3 command
    int         m_phase;
    logic [7:0] m_mode, m_sa, m_sb, m_txd;
    bit         m_txe, m_rxe, m_brk, m_dtr, m_rts, m_txl, m_rxt, m_err;
    bit         w_prev, r_prev;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_mode = 0; m_sa = 0; m_sb = 0; m_txd = 0;
        m_txe = 0; m_rxe = 0; m_brk = 0; m_dtr = 0; m_rts = 0;
        m_txl = 0; m_rxt = 0; m_err = 0; w_prev = 0; r_prev = 0;
    endtask

    task automatic model_ctl(input logic [7:0] v);
        case (m_phase)
            0: begin m_mode = v; m_phase = (v[1:0] == 2'b00) ? 1 : 3; end
            1: begin m_sa = v; m_phase = m_mode[7] ? 3 : 2; end
            2: begin m_sb = v; m_phase = 3; end
            default: begin
                if (v[6]) begin
                    m_txe = 0; m_rxe = 0; m_brk = 0; m_dtr = 0; m_rts = 0;
                    m_phase = 0;
                end else begin
                    m_txe = v[0]; m_dtr = v[1]; m_rxe = v[2]; m_brk = v[3];
                    m_rts = v[5]; m_err = v[4];
                end
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else begin
            bit wa, ra;
            wa = !cs_n && !wr_n;
            ra = !cs_n && !rd_n;
            m_txl = 0; m_rxt = 0; m_err = 0;
            if (wa && !w_prev) begin
                if (cd) model_ctl(din);
                else begin m_txd = din; m_txl = 1; end
            end
            if (ra && !r_prev && !cd) m_rxt = 1;
            w_prev = wa; r_prev = ra;
        end
        go = 1'b1;
    end

    // per-clock comparison, away from the edge
    always begin
        @(negedge clk);
        #3;
        if (go) begin
            logic [7:0] e_dout;
            e_dout = (!cs_n && !rd_n) ? (cd ? status_in : rx_data) : 8'h00;
            chk("R1/R3", "dout", dout, e_dout);
            chk("R2", "tx_data", tx_data, m_txd);
            chk("R2", "tx_load", tx_load, m_txl);
            chk("R3", "rx_take", rx_take, m_rxt);
            chk("R4", "mode", {frame_hi, par_even, par_en, char_len, baud_sel}, m_mode);
            chk("R5", "sync_a", sync_a, m_sa);
            chk("R5", "sync_b", sync_b, m_sb);
            chk("R6", "tx_en", tx_en, m_txe);
            chk("R6", "rx_en", rx_en, m_rxe);
            chk("R6", "brk", brk, m_brk);
            chk("R6", "dtr_n", dtr_n, !m_dtr);
            chk("R6", "rts_n", rts_n, !m_rts);
            chk("R7", "err_clr", err_clr, m_err);
        end
    end

    task automatic bus_wr(input logic c, input logic [7:0] v, input logic sel_n = 1'b0);
        @(negedge clk);
        cs_n = sel_n; wr_n = 1'b0; cd = c; din = v;
        @(negedge clk);
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic c);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; cd = c;
        @(negedge clk);
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #4;
        chk("R9", "reset dtr_n", dtr_n, 1);
        chk("R9", "reset rts_n", rts_n, 1);
        chk("R9", "reset tx_en", tx_en, 0);

        // R1: strobe with chip select high must do nothing
        bus_wr(1'b1, 8'h4E, 1'b1);
        chk("R1", "baud after deselected write", baud_sel, 0);
        bus_wr(1'b0, 8'h99, 1'b1);
        chk("R1", "tx_data after deselected write", tx_data, 0);

        // R4: async mode word, then R6 command
        bus_wr(1'b1, 8'h4E);
        chk("R4", "baud_sel", baud_sel, 2);
        chk("R4", "char_len", char_len, 3);
        bus_wr(1'b1, 8'h27);
        chk("R6", "dtr_n low", dtr_n, 0);
        chk("R6", "rts_n low", rts_n, 0);
        chk("R10", "mode kept after command", baud_sel, 2);

        // R2 data write, R3 reads
        bus_wr(1'b0, 8'h55);
        chk("R2", "tx_data", tx_data, 8'h55);
        bus_rd(1'b0);
        bus_rd(1'b1);
        rx_data = 8'hA7; status_in = 8'h01;
        bus_rd(1'b0);

        // R7 error reset, R6 break
        bus_wr(1'b1, 8'h10);
        bus_wr(1'b1, 8'h08);
        chk("R6", "brk", brk, 1);

        // R8: internal reset with every other bit set
        bus_wr(1'b1, 8'h7F);
        chk("R8", "tx_en cleared", tx_en, 0);
        chk("R8", "brk cleared", brk, 0);
        chk("R8", "mode retained", baud_sel, 2);

        // R5: sync mode with two sync characters
        bus_wr(1'b1, 8'h1C);
        bus_wr(1'b1, 8'h16);
        bus_wr(1'b1, 8'h17);
        chk("R5", "sync_b", sync_b, 8'h17);
        bus_wr(1'b1, 8'h02);
        chk("R6", "dtr_n", dtr_n, 0);
        chk("R10", "mode after cmd", baud_sel, 0);

        // R5: single sync character
        bus_wr(1'b1, 8'h40);
        bus_wr(1'b1, 8'h8C);
        bus_wr(1'b1, 8'hAA);
        bus_wr(1'b1, 8'h21);
        chk("R5", "sync_a single", sync_a, 8'hAA);
        chk("R5", "sync_b untouched", sync_b, 8'h17);
        chk("R6", "rts_n", rts_n, 0);

        // R9: external reset in the middle of a sync sequence
        bus_wr(1'b1, 8'h40);
        bus_wr(1'b1, 8'h00);
        pulse_rst();
        chk("R9", "mode cleared", baud_sel, 0);
        bus_wr(1'b1, 8'hF1);
        chk("R9", "next write is mode", frame_hi, 3);
        bus_wr(1'b1, 8'h25);
        chk("R6", "rx_en", rx_en, 1);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule